// File: doc/BRIEF.md
# Rotatable Pixel Coordinate Scanner

This block produces one fractal-space coordinate record for every pixel of a video frame. A host first loads a start point and two increment vectors through a small register port. One vector is added per step to the right, the other per step down. A single-cycle frame-start pulse, raised when the display's beam position wraps to zero, begins a scan. The block then walks the frame in raster order and presents each record on a valid/ready stream. Because both increment vectors carry an X and a Y part, the sampled grid can be rotated and scaled freely.

Each record holds an X coordinate, a Y coordinate and the linear pixel number, counted the same way as the video timing's pixel counter. Downstream engines that finish out of order use this number to sort the results. When the scan finishes, a frame counter increments, so the host can tell when the next frame's parameters may be written.

Back-pressure follows the usual stream rules. A record transfers on every rising edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the record is held unchanged and the scan does not move. `out_valid` never depends combinationally on `out_ready`. The default frame is 1920 columns by 1080 rows.

Top module: `pix_coord_scanner`

## Requirements
- R1: After reset, `out_valid` is 0 and `frame_count` is 0.
- R2: A `frame_start` pulse while idle raises `out_valid` at the next rising edge. The first record then carries the start point (X from register 0, Y from register 1) and pixel number 0.
- R3: A step to the next column within a row adds the column vector (X part register 2, Y part register 3) to the previous record's coordinate.
- R4: The first record of a new row equals the first record of the previous row plus the row vector (X part register 4, Y part register 5).
- R5: The record at row r, column c carries pixel number r*COLS + c.
- R6: With `out_ready` held high, one record transfers per clock. After exactly COLS*ROWS transfers, `out_valid` is 0 at the next edge.
- R7: While `out_valid` is 1 and `out_ready` is 0, the record is held stable and no record is skipped or repeated.
- R8: `frame_count` increments by one at the edge that accepts the last record of a frame, and at no other time.
- R9: The column and row vectors are copied at the accepted `frame_start`. Host writes made during a scan do not change the frame in progress, and they apply to the next frame.
- R10: A `frame_start` pulse during a scan is ignored. The scan continues without restarting.
- R11: Coordinates are 18-bit two's-complement values. Additions wrap modulo 2^18 and do not saturate.
- R12: Writes to register addresses 6 and 7 have no effect on any register or on the records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame-start pulse; accepted only when idle |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 3 | Register select: 0 start X, 1 start Y, 2 column dX, 3 column dY, 4 row dX, 5 row dY |
| host_wdata | input | 18 | Register write data |
| out_valid | output | 1 | A record is presented |
| out_ready | input | 1 | Consumer accepts the record |
| out_x | output | 18 | Record X coordinate |
| out_y | output | 18 | Record Y coordinate |
| out_pix | output | PIX_W | Record linear pixel number |
| frame_count | output | FCNT_W | Completed-frame counter |

## Verification
A wrong column or row counter shows up first in `out_pix`. It appears at the first transfer after the fault, and at the end of a row it also corrupts the coordinates through a wrong row-base selection. A corrupted accumulator or shadow vector produces a wrong X or Y on the very next record. A wrong busy flag shows up either as a missing or extra `out_valid` cycle at the end of the frame, or as a restart when a `frame_start` pulse arrives mid-scan. Frame-counter faults are visible one edge after the final transfer.

// File: rtl/pix_scan_pkg.sv
package pix_scan_pkg;
  localparam int COORD_W = 18;
  localparam int NUM_REGS = 6;

  typedef logic [COORD_W-1:0] coord_t;

  typedef struct packed {
    coord_t x;
    coord_t y;
  } cvec_t;

  typedef enum logic [2:0] {
    SEL_START_X = 3'd0,
    SEL_START_Y = 3'd1,
    SEL_COL_DX  = 3'd2,
    SEL_COL_DY  = 3'd3,
    SEL_ROW_DX  = 3'd4,
    SEL_ROW_DY  = 3'd5
  } reg_sel_e;

  // two's-complement add, wraps modulo 2^COORD_W
  function automatic cvec_t vec_add(cvec_t a, cvec_t b);
    cvec_t s;
    s.x = a.x + b.x;
    s.y = a.y + b.y;
    return s;
  endfunction
endpackage

// File: rtl/scan_param_bank.sv
module scan_param_bank
  import pix_scan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  coord_t     wr_data,
  input  logic       load,
  output cvec_t      live_start,
  output cvec_t      work_col,
  output cvec_t      work_row
);
  coord_t host_q [NUM_REGS];
  coord_t shad_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        host_q[i] <= '0;
        shad_q[i] <= '0;
      end else begin
        if (wr_en && (wr_addr == 3'(i)))
          host_q[i] <= wr_data;
        if (load)
          shad_q[i] <= host_q[i];
      end
    end
  end

  assign live_start = '{x: host_q[SEL_START_X], y: host_q[SEL_START_Y]};
  assign work_col   = '{x: shad_q[SEL_COL_DX],  y: shad_q[SEL_COL_DY]};
  assign work_row   = '{x: shad_q[SEL_ROW_DX],  y: shad_q[SEL_ROW_DY]};

  // R9: working vectors only move at a load
  a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(work_col) && $stable(work_row));
endmodule

// File: rtl/scan_position.sv
module scan_position #(
  parameter int COLS = 1920,
  parameter int ROWS = 1080,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int PIX_W = (COLS * ROWS > 1) ? $clog2(COLS * ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             advance,
  output logic             busy,
  output logic             row_end,
  output logic             frame_last,
  output logic [PIX_W-1:0] pix
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;

  assign row_end    = (col_q == COL_LAST);
  assign frame_last = row_end && (row_q == ROW_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      col_q <= '0;
      row_q <= '0;
      pix   <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        col_q <= '0;
        row_q <= '0;
        pix   <= '0;
      end
    end else if (advance) begin
      if (frame_last) begin
        busy <= 1'b0;
      end else begin
        pix <= pix + 1'b1;
        if (row_end) begin
          col_q <= '0;
          row_q <= row_q + 1'b1;
        end else begin
          col_q <= col_q + 1'b1;
        end
      end
    end
  end

  // R6: column and row stay inside the frame
  a_r6_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (col_q <= COL_LAST) && (row_q <= ROW_LAST));
  // R10: a start during a scan neither restarts nor drops the scan
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !advance |=> busy && $stable(pix));
  // R5: pixel number climbs by one per transfer
  a_r5_pix_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy && advance && !frame_last |=> pix == $past(pix) + 1'b1);
endmodule

// File: rtl/scan_coord_step.sv
module scan_coord_step
  import pix_scan_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  advance,
  input  logic  row_end,
  input  cvec_t live_start,
  input  cvec_t col_step,
  input  cvec_t row_step,
  output cvec_t cur
);
  cvec_t row_base_q;
  cvec_t next_row;

  assign next_row = vec_add(row_base_q, row_step);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur        <= '0;
      row_base_q <= '0;
    end else if (load) begin
      cur        <= live_start;
      row_base_q <= live_start;
    end else if (advance) begin
      if (row_end) begin
        cur        <= next_row;
        row_base_q <= next_row;
      end else begin
        cur <= vec_add(cur, col_step);
      end
    end
  end

  // R7: no step means no coordinate change
  a_r7_coord_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !advance |=> $stable(cur));
endmodule

// File: rtl/pix_coord_scanner.sv
module pix_coord_scanner
  import pix_scan_pkg::*;
#(
  parameter int COLS   = 1920,
  parameter int ROWS   = 1080,
  parameter int FCNT_W = 16,
  localparam int PIX_W = (COLS * ROWS > 1) ? $clog2(COLS * ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              host_wr,
  input  logic [2:0]        host_addr,
  input  logic [17:0]       host_wdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [17:0]       out_x,
  output logic [17:0]       out_y,
  output logic [PIX_W-1:0]  out_pix,
  output logic [FCNT_W-1:0] frame_count
);
  logic  busy, row_end, frame_last, load, advance;
  cvec_t live_start, work_col, work_row, cur;

  assign load    = frame_start && !busy;
  assign advance = busy && out_ready;

  scan_param_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (host_wr),
    .wr_addr    (host_addr),
    .wr_data    (host_wdata),
    .load       (load),
    .live_start (live_start),
    .work_col   (work_col),
    .work_row   (work_row)
  );

  scan_position #(.COLS(COLS), .ROWS(ROWS)) u_pos (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (frame_start),
    .advance    (advance),
    .busy       (busy),
    .row_end    (row_end),
    .frame_last (frame_last),
    .pix        (out_pix)
  );

  scan_coord_step u_step (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .advance    (advance),
    .row_end    (row_end),
    .live_start (live_start),
    .col_step   (work_col),
    .row_step   (work_row),
    .cur        (cur)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      frame_count <= '0;
    else if (advance && frame_last)
      frame_count <= frame_count + 1'b1;
  end

  assign out_valid = busy;
  assign out_x     = cur.x;
  assign out_y     = cur.y;

  // R7: a stalled record stays put
  a_r7_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_x) && $stable(out_y) && $stable(out_pix));
  // R8: end of scan and counter step coincide
  a_r8_count_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> frame_count == $past(frame_count) + 1'b1);
  a_r8_count_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> $stable(frame_count) || !out_valid);
  // R2: a scan opens at pixel zero
  a_r2_first_pix: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_pix == '0);
endmodule

// File: tb/sim_pix_coord_scanner.sv
module sim_pix_coord_scanner;
  localparam int COLS  = 6;
  localparam int ROWS  = 4;
  localparam int NPIX  = COLS * ROWS;
  localparam int PIX_W = $clog2(NPIX);
  localparam int LIMIT = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic host_wr = 1'b0;
  logic [2:0] host_addr = '0;
  logic [17:0] host_wdata = '0;
  logic out_ready = 1'b0;
  logic out_valid;
  logic [17:0] out_x, out_y;
  logic [PIX_W-1:0] out_pix;
  logic [15:0] frame_count;

  int n_chk = 0;
  int n_bad = 0;
  int exp_frames = 0;
  logic [17:0] mirror [6];

  always #5 clk = ~clk;

  pix_coord_scanner #(.COLS(COLS), .ROWS(ROWS), .FCNT_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_x(out_x), .out_y(out_y), .out_pix(out_pix),
    .frame_count(frame_count)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] model(logic [17:0] s, logic [17:0] cd, logic [17:0] rd, int r, int c);
    return s + 18'(c) * cd + 18'(r) * rd;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [17:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    if (a < 3'd6) mirror[a] = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic set_all(input logic [17:0] sx, sy, cx, cy, rx, ry);
    wr(3'd0, sx); wr(3'd1, sy); wr(3'd2, cx); wr(3'd3, cy); wr(3'd4, rx); wr(3'd5, ry);
  endtask

  // caller stands at a negedge; returns at a negedge
  task automatic run_frame(input int ready_pct, input bit disturb, input string tag);
    logic [17:0] p [6];
    int r = 0, c = 0, n = 0, k = 0;
    bit rdy, prev_rdy = 1'b1;
    logic [17:0] px = '0, py = '0;
    logic [PIX_W-1:0] pp = '0;
    for (int i = 0; i < 6; i++) p[i] = mirror[i];
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    check(out_valid === 1'b1, "R2 valid after start", out_valid, 1);
    check(out_x === p[0] && out_y === p[1] && out_pix === '0, "R2 first record", {out_x, out_y}, {p[0], p[1]});
    while (n < NPIX && out_valid === 1'b1) begin
      check(out_x === model(p[0], p[2], p[4], r, c), {tag, " x"}, out_x, model(p[0], p[2], p[4], r, c));
      check(out_y === model(p[1], p[3], p[5], r, c), {tag, " y"}, out_y, model(p[1], p[3], p[5], r, c));
      check(int'(out_pix) == r * COLS + c, "R5 pixel number", out_pix, r * COLS + c);
      if (!prev_rdy)
        check(out_x === px && out_y === py && out_pix === pp, "R7 stall hold", {out_x, out_y}, {px, py});
      px = out_x; py = out_y; pp = out_pix;
      rdy = (($urandom % 100) < ready_pct);
      out_ready = rdy;
      if (disturb && k == 2) begin
        host_wr = 1'b1; host_addr = 3'd2; host_wdata = p[2] + 18'h111; mirror[2] = host_wdata;
      end
      if (disturb && k == 4) frame_start = 1'b1;  // R10: mid-scan start
      @(negedge clk);
      host_wr = 1'b0; frame_start = 1'b0;
      if (rdy) begin
        n++;
        if (c == COLS - 1) begin c = 0; r++; end else c++;
      end
      prev_rdy = rdy;
      k++;
    end
    out_ready = 1'b0;
    exp_frames++;
    check(n == NPIX, "R6 record count", n, NPIX);
    check(out_valid === 1'b0, "R6 valid drops after last", out_valid, 0);
    check(frame_count == 16'(exp_frames), "R8 frame counter", frame_count, exp_frames);
    @(negedge clk);
  endtask

  initial begin
    #(LIMIT * 10);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd77));
    for (int i = 0; i < 6; i++) mirror[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R1 valid at reset", out_valid, 0);
    check(frame_count === 16'd0, "R1 counter at reset", frame_count, 0);
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 idle without start", out_valid, 0);

    // R3 R4 directed, full-rate stream
    set_all(18'h00100, 18'h3FF00, 18'h00010, 18'h00002, 18'h3FFFD, 18'h00040);
    run_frame(100, 1'b0, "R3/R4/R6");
    // R7 random back-pressure, rotated deltas
    set_all(18'h01234, 18'h00777, 18'h3FFF1, 18'h0000F, 18'h3FFF1, 18'h3FFF1);
    run_frame(50, 1'b0, "R7");
    // R11 wraparound at the positive and negative ends
    set_all(18'h1FFF0, 18'h20005, 18'h00009, 18'h3FFFB, 18'h1FFFF, 18'h20001);
    run_frame(70, 1'b0, "R11");
    // R9 and R10: writes and a start pulse during the scan
    set_all(18'h00000, 18'h00000, 18'h00005, 18'h00003, 18'h00100, 18'h00200);
    run_frame(80, 1'b1, "R9/R10");
    // R9: the write made mid-scan applies now
    check(mirror[2] == 18'h00116, "R9 mirror updated", mirror[2], 18'h00116);
    run_frame(100, 1'b0, "R9 next frame");
    // R12: unused addresses
    wr(3'd6, 18'h2AAAA);
    wr(3'd7, 18'h15555);
    run_frame(60, 1'b0, "R12");
    // random parameter sets
    for (int f = 0; f < 6; f++) begin
      set_all(18'($urandom), 18'($urandom), 18'($urandom), 18'($urandom), 18'($urandom), 18'($urandom));
      run_frame(30 + 10 * f, 1'b0, "R3/R4/R11 random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule